// File: doc/BRIEF.md
# Ping-Pong Dual-Thread Buffer Writer

This block takes a stream of 32-bit words from an external source and distributes them over two buffer threads that take turns. One downstream consumer drains the threads alternately, so the word order is preserved. Each thread fills one fixed-size buffer. When the buffer is full, or when the source marks the last word of a transfer, the block closes the buffer with a commit strobe. It then moves to the other thread.

Before the block accepts any word into a thread, it sits in a ready-check state. There it waits for that thread's buffer-ready flag. A commit always shares its cycle with a data write, so a buffer is never committed empty. A transfer whose length is not a multiple of the buffer size is still delivered completely: its last word closes the partial buffer. The block does not wait for a later transfer to push that buffer out.

The input side is a valid/ready handshake. Each thread has its own ready input, its own write strobe and its own commit strobe, and the two threads share one data output.

Top module: `ppw_dual_writer`

## Requirements
- R1: A buffer holds BUF_BYTES / (DATA_W/8) words. With the defaults of 2048 bytes and 32-bit data, that is 512 words. The internal word counter therefore loads 511, not 2048. When no last-word marker is present, the commit comes exactly with the 512th write of the buffer, and never earlier.
- R2: `commit[t]` is asserted only in a cycle where `wr_en[t]` is also asserted. No commit ever appears without a written word.
- R3: Buffers alternate strictly between the threads. Bit 0 of `wr_en` and `commit` is thread 0, and bit 1 is thread 1. At most one `wr_en` bit is high in any cycle. After a commit on thread t, the next write goes to the other thread.
- R4: In the cycle after any commit, `in_ready` is low, because the block is in the ready-check state. The block leaves that state only when the new thread's `thr_rdy` bit is high. While that bit stays low, no word is accepted.
- R5: `in_ready` is high only while the block is filling and the current thread's `thr_rdy` bit is high. A write occurs exactly when `in_valid` and `in_ready` are both high. `wr_data` then equals `in_data`.
- R6: An accepted word with `in_last` high commits the current buffer, even if the buffer is only partly full. The next transfer starts a fresh buffer on the other thread.
- R7: Words reach the buffers in arrival order, with no word lost or duplicated, under any pattern of `in_valid` gaps and `thr_rdy` stalls.
- R8: In the first cycle after reset, the block is in the ready-check state on thread 0: `in_ready`, `wr_en` and `commit` are all low. The first buffer after reset is written on thread 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_data | input | DATA_W | Source word |
| in_last | input | 1 | Current word is the final word of a transfer |
| in_ready | output | 1 | Block accepts the word this cycle |
| thr_rdy | input | 2 | Per-thread buffer-ready flag |
| wr_en | output | 2 | Per-thread write strobe |
| wr_data | output | DATA_W | Word being written |
| commit | output | 2 | Per-thread buffer close strobe, coincident with the final write |

## Verification
The assertions check the following on every cycle:
- commit always coincides with a write on the same thread;
- writes are one-hot and follow the alternating thread;
- the handshake is gated by the current thread's ready flag;
- there is a dead ready-check cycle after every commit;
- a buffer closes at its full word count and not before, unless the last-word marker is set.

Only the bench's scenarios can show the end-to-end properties. These are:
- a counting pattern arrives complete and in order across many buffers and several transfers;
- each partial tail buffer has the expected size;
- a held-off ready flag stalls the block indefinitely without losing the waiting word.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    typedef enum logic {
        ST_CHECK = 1'b0,
        ST_FILL  = 1'b1
    } ppw_state_e;

    typedef struct packed {
        logic fire;
        logic close;
    } ppw_beat_t;

    function automatic int unsigned words_per_buf(input int unsigned bytes,
                                                  input int unsigned bus_bits);
        return bytes / (bus_bits / 8);
    endfunction

endpackage

// File: rtl/ppw_word_counter.sv
module ppw_word_counter #(
    parameter int CNT_W    = 9,
    parameter int LOAD_VAL = 511
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic is_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= CNT_W'(LOAD_VAL);
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/ppw_thread_sel.sv
module ppw_thread_sel (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic cur
);
    always_ff @(posedge clk) begin
        if (rst)       cur <= 1'b0;
        else if (flip) cur <= ~cur;
    end
endmodule

// File: rtl/ppw_dual_writer.sv
module ppw_dual_writer #(
    parameter int BUF_BYTES = 2048,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [1:0]        thr_rdy,
    output logic [1:0]        wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        commit
);
    import ppw_pkg::*;

    localparam int WORDS   = words_per_buf(BUF_BYTES, DATA_W);
    localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int NUM_THR = 2;

    ppw_state_e state_q, state_d;
    ppw_beat_t  beat;
    logic       cur;
    logic       is_zero;
    logic       load;
    logic       cur_rdy;

    ppw_thread_sel u_sel (
        .clk  (clk),
        .rst  (rst),
        .flip (beat.close),
        .cur  (cur)
    );

    // Last-word index, not a byte count.
    ppw_word_counter #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (WORDS - 1)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .dec     (beat.fire && !beat.close),
        .is_zero (is_zero)
    );

    always_comb begin
        cur_rdy    = thr_rdy[cur];
        in_ready   = (state_q == ST_FILL) && cur_rdy;
        beat.fire  = in_valid && in_ready;
        beat.close = beat.fire && (is_zero || in_last);
        load       = (state_q == ST_CHECK) && cur_rdy;
        state_d    = state_q;
        case (state_q)
            ST_CHECK: if (cur_rdy)    state_d = ST_FILL;
            ST_FILL:  if (beat.close) state_d = ST_CHECK;
            default:                  state_d = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CHECK;
        else     state_q <= state_d;
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign wr_en[t]  = beat.fire  && (cur == 1'(t));
        assign commit[t] = beat.close && (cur == 1'(t));
    end

    assign wr_data = in_data;
endmodule

// File: rtl/ppw_dual_writer_chk.sv
module ppw_dual_writer_chk #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              in_ready,
    input logic [1:0]        thr_rdy,
    input logic [1:0]        wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        commit
);
    localparam int WC_W = $clog2(WORDS) + 1;

    logic [WC_W-1:0] wcnt;
    logic            ethr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            ethr <= 1'b0;
        end else begin
            if (|commit)     wcnt <= '0;
            else if (|wr_en) wcnt <= wcnt + 1'b1;
            if (|commit)     ethr <= ~ethr;
        end
    end

    p_commit_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
        (commit & ~wr_en) == 2'b00);

    p_onehot_write_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    p_alternate_r3: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> wr_en[ethr]);

    p_check_after_commit_r4: assert property (@(posedge clk) disable iff (rst)
        (|commit) |=> !in_ready);

    p_ready_gate_r5: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> thr_rdy[ethr]);

    p_handshake_r5: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) == (in_valid && in_ready));

    p_data_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> (wr_data == in_data));

    p_full_commit_r1: assert property (@(posedge clk) disable iff (rst)
        ((|wr_en) && wcnt == WC_W'(WORDS - 1)) |-> (|commit));

    p_no_early_commit_r1: assert property (@(posedge clk) disable iff (rst)
        ((|commit) && !in_last) |-> (wcnt == WC_W'(WORDS - 1)));

    p_last_closes_r6: assert property (@(posedge clk) disable iff (rst)
        ((|wr_en) && in_last) |-> (|commit));

    p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ready && wr_en == 2'b00 && commit == 2'b00));
endmodule

bind ppw_dual_writer ppw_dual_writer_chk #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .thr_rdy  (thr_rdy),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .commit   (commit)
);

// File: tb/ppw_dual_writer_tb_top.sv
module ppw_dual_writer_tb_top;
    localparam int DATA_W = 32;
    localparam int WORDS  = 512;
    localparam int NVEC   = 5;
    // length, stall level, expected buffers, expected tail size
    localparam int VEC [NVEC][4] = '{
        '{1023, 0, 2, 511},
        '{ 512, 2, 1, 512},
        '{   1, 3, 1,   1},
        '{ 700, 1, 2, 188},
        '{1536, 2, 3, 512}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic [1:0]        thr_rdy = 2'b00;
    logic [1:0]        wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]        commit;

    always #2 clk = ~clk;

    ppw_dual_writer #(.BUF_BYTES(2048), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .thr_rdy(thr_rdy),
        .wr_en(wr_en), .wr_data(wr_data), .commit(commit)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    bit mon_en   = 0;
    bit exp_thr  = 0;
    int exp_word = 0;
    int buf_words = 0;
    int bufs_this = 0;
    int tail_size = 0;
    int got_words = 0;
    bit after_commit = 0;

    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (after_commit)
                chk(!in_ready, "R4 ready low after commit", int'(in_ready), 0);
            after_commit = 0;
            chk((commit & ~wr_en) == 2'b00, "R2 commit without write", int'(commit), int'(wr_en));
            if (wr_en != 2'b00) begin
                chk(wr_en == (exp_thr ? 2'b10 : 2'b01), "R3 thread order", int'(wr_en), exp_thr ? 2 : 1);
                chk(int'(wr_data) == exp_word, "R7 word order", int'(wr_data), exp_word);
                exp_word++;
                got_words++;
                buf_words++;
                if (commit != 2'b00) begin
                    if (!in_last)
                        chk(buf_words == WORDS, "R1 full buffer size", buf_words, WORDS);
                    tail_size = buf_words;
                    bufs_this++;
                    buf_words = 0;
                    exp_thr = ~exp_thr;
                    after_commit = 1;
                end else begin
                    chk(buf_words < WORDS, "R1 buffer not over full", buf_words, WORDS - 1);
                    chk(!in_last, "R6 last word commits", int'(in_last), 0);
                end
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    int drv_word = 0;

    task automatic run_xfer(input int len, input int stall);
        int sent = 0;
        bit sn;
        while (sent < len) begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sn = (stall > 0) && ((lfsr & ((16'd1 << stall) - 1)) == 0);
            thr_rdy[0] = !(sn && lfsr[7]);
            thr_rdy[1] = !(sn && !lfsr[7]);
            in_valid = !((stall > 0) && lfsr[9:8] == 2'b00);
            in_data  = DATA_W'(drv_word);
            in_last  = (sent == len - 1);
            @(negedge clk);
            if (in_valid && in_ready) begin
                sent++;
                drv_word++;
            end
        end
        @(posedge clk); #1;
        in_valid = 0;
        in_last  = 0;
        thr_rdy  = 2'b11;
    endtask

    initial begin
        // reset and first cycles
        rst = 1;
        thr_rdy = 2'b11;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!in_ready, "R8 reset in_ready low", int'(in_ready), 0);
        chk(wr_en == 2'b00, "R8 reset wr_en low", int'(wr_en), 0);
        chk(commit == 2'b00, "R8 reset commit low", int'(commit), 0);
        @(negedge clk);
        chk(in_ready, "R8 leaves ready-check when thread 0 ready", int'(in_ready), 1);
        mon_en = 1;

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            bufs_this = 0;
            got_words = 0;
            tail_size = 0;
            run_xfer(VEC[v][0], VEC[v][1]);
            repeat (3) @(negedge clk);
            chk(got_words == VEC[v][0], "R7 transfer complete", got_words, VEC[v][0]);
            chk(bufs_this == VEC[v][2], "R6 buffer count", bufs_this, VEC[v][2]);
            chk(tail_size == VEC[v][3], "R6 tail buffer size", tail_size, VEC[v][3]);
            chk(buf_words == 0, "R6 no open buffer left", buf_words, 0);
        end

        // next thread held not ready: nothing accepted
        @(posedge clk); #1;
        thr_rdy  = 2'b00;
        in_valid = 1;
        in_last  = 1;
        in_data  = DATA_W'(drv_word);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!in_ready, "R4 waits for thread ready", int'(in_ready), 0);
            chk(wr_en == 2'b00, "R4 no write while waiting", int'(wr_en), 0);
        end
        bufs_this = 0;
        got_words = 0;
        tail_size = 0;
        run_xfer(1, 0);
        repeat (3) @(negedge clk);
        chk(got_words == 1, "R4 held word delivered once", got_words, 1);
        chk(tail_size == 1, "R6 single-word buffer", tail_size, 1);
        chk(exp_word == drv_word, "R7 total words", exp_word, drv_word);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule